// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time and Short-Circuit Shutdown

This block converts a direction bit and a PWM bit into four registered gate enables for an external full bridge built from NMOS switches. One half-bridge has a high-side and a low-side switch driving one motor terminal, and the other half-bridge does the same for the second terminal. In either rotation direction, the high side of the source leg stays on. The opposite leg chops: its low side follows PWM and its high side takes the complement, so the motor current recirculates through the two high sides while PWM is low. A PWM input held high (100% duty) gives a constant bridge state.

Every turn-on waits until the other switch in the same leg has been off for a programmable number of clock cycles. A change of direction restarts that wait in both legs. The direction and PWM inputs are synchronised with a two-flop chain before use.

Each switch has a desaturation comparator input. A comparator is only checked after its switch has been on for a programmable blanking time. A detection removes all four gates and latches a short-circuit flag. The latch is held until the next PWM edge. A separate supply-droop input removes the gates and raises the flag at once, with no blanking and no latching.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `enable` is low, all four bits of `gate_on` are 0 from the next clock edge on, whatever `dir_in` and `pwm_in` are.
- R2: `gate_on` bit order is bit0 = high side A, bit1 = low side A, bit2 = high side B, bit3 = low side B. With `enable` high and `dir_in` = 0, the settled output is 4'b0101 for PWM low and 4'b1001 for PWM high. High side A stays on, low side B follows PWM, and high side B follows the inverse of PWM.
- R3: With `enable` high and `dir_in` = 1, the settled output is 4'b0101 for PWM low and 4'b0110 for PWM high. High side B stays on, low side A follows PWM, and high side A follows the inverse of PWM.
- R4: The two gates of one leg are never on together. After one gate of a leg turns off, the other gate turns on no earlier than max(D,1) cycles later, and exactly then when it is already requested. D is `dead_cycles`, so D = 0 or 1 gives a gap of one cycle.
- R5: After a change of the synchronised direction, a gate that was off in either leg turns on only after that leg has been fully off for max(D,1) cycles. On a reversal with PWM high, all four gates are off for exactly max(D,1) cycles. A gate that stays requested across the reversal stays on.
- R6: With `pwm_in` held high, the gate outputs stay constant in both directions (100% duty, no glitch).
- R7: A desaturation bit is ignored until its gate has been on for B cycles, where B is `blank_cycles`. A bit that is set while its gate is off is also ignored. An enabled detection turns all gates off and sets `short_flag` at the next edge, so a gate that switches on while its comparator is already set stays on for B+1 cycles.
- R8: After a short-circuit shutdown, the gates stay off and `short_flag` stays high, even across direction changes, until the next synchronised edge of PWM. That edge clears the flag and lets the gates selected by `dir_in` turn on again.
- R9: `pbat_low` turns all gates off and sets `short_flag` at the next edge, with no blanking. Both are restored one edge after it drops.
- R10: During reset, `gate_on` is 0 and `short_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global drive permission |
| dir_in | input | 1 | Rotation direction (asynchronous) |
| pwm_in | input | 1 | PWM command (asynchronous) |
| desat_in | input | 4 | Per-switch drain-source overvoltage comparators, same bit order as gate_on |
| pbat_low | input | 1 | Bridge supply below its safe level |
| dead_cycles | input | CNT_W | Non-overlap time in clock cycles |
| blank_cycles | input | CNT_W | Desaturation blanking time in clock cycles |
| gate_on | output | 4 | Gate commands {LB, HB, LA, HA} |
| short_flag | output | 1 | Short-circuit or supply-droop shutdown indication |

## Verification
The bench builds the block with `CNT_W` = 4 and `SYNC_STAGES` = 2. The narrow counters mean the leg-idle and on-time counters reach their saturation value of 15 during the latched shutdown and the long 100% duty holds, so saturated counters are exercised. Dead times of 0, 1, 3 and 4 cycles and blanking times of 2 and 5 cycles are used, which covers the one-cycle minimum gap, exact gap lengths and the B+1 on-time before a trip.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
   localparam int NUM_GATES = 4;
   localparam int GI_HA = 0;
   localparam int GI_LA = 1;
   localparam int GI_HB = 2;
   localparam int GI_LB = 3;

   // Requested bridge state for a direction and PWM level; the source leg
   // high side stays on, the opposite leg chops.
   function automatic logic [NUM_GATES-1:0] bridge_request(input logic dir, input logic pwm);
      logic [NUM_GATES-1:0] r;
      r = '0;
      if (!dir) begin
         r[GI_HA] = 1'b1;
         r[GI_HB] = ~pwm;
         r[GI_LB] = pwm;
      end else begin
         r[GI_HB] = 1'b1;
         r[GI_HA] = ~pwm;
         r[GI_LA] = pwm;
      end
      return r;
   endfunction
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("hbg_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_hi,
   input  logic             req_lo,
   input  logic             allow,
   input  logic             restart,
   input  logic [CNT_W-1:0] dead,
   output logic             hi_q,
   output logic             lo_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W:0]   ONE_W   = 1;

   logic [CNT_W-1:0] idle_cnt;
   logic             gap_ok;
   logic             hi_n, lo_n;

   // idle_cnt holds (cycles the leg has been fully off) - 1 as seen at the next edge
   always_comb begin
      gap_ok = !restart && (({1'b0, idle_cnt} + ONE_W) >= {1'b0, dead});
      hi_n   = allow && req_hi && (hi_q || (!lo_q && gap_ok));
      lo_n   = allow && req_lo && (lo_q || (!hi_q && gap_ok));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= 1'b0;
         lo_q     <= 1'b0;
         idle_cnt <= '0;
      end else begin
         hi_q <= hi_n;
         lo_q <= lo_n;
         if (hi_q || lo_q || restart) idle_cnt <= '0;
         else if (idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
      end
   end

   p_leg_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q && lo_q));
   p_hi_after_lo_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_q) |-> !$past(lo_q));
   p_lo_after_hi_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_q) |-> !$past(hi_q));
endmodule

// File: rtl/hbg_desat.sv
module hbg_desat #(
   parameter int NG    = 4,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NG-1:0]    gate_q,
   input  logic [NG-1:0]    desat,
   input  logic [CNT_W-1:0] blank,
   input  logic             pwm_edge,
   output logic             trip,
   output logic             sc_latch
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [NG-1:0] armed;

   for (genvar g = 0; g < NG; g++) begin : g_chan
      logic [CNT_W-1:0] on_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 on_cnt <= '0;
         else if (!gate_q[g])        on_cnt <= '0;
         else if (on_cnt != CNT_MAX) on_cnt <= on_cnt + 1'b1;
      end
      assign armed[g] = gate_q[g] && (on_cnt >= blank);
   end

   assign trip = |(armed & desat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sc_latch <= 1'b0;
      else if (trip)     sc_latch <= 1'b1;
      else if (pwm_edge) sc_latch <= 1'b0;
   end

   p_latched_gates_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sc_latch |-> (gate_q == '0));
   p_release_on_pwm_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sc_latch) |-> $past(pwm_edge));
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
   import hbg_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             dir_in,
   input  logic             pwm_in,
   input  logic [3:0]       desat_in,
   input  logic             pbat_low,
   input  logic [CNT_W-1:0] dead_cycles,
   input  logic [CNT_W-1:0] blank_cycles,
   output logic [3:0]       gate_on,
   output logic             short_flag
);
   localparam int NUM_LEGS = NUM_GATES / 2;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
      $error("hbridge_gate_seq: CNT_W must be 2..16");
   end

   logic [1:0]           sync_q;
   logic                 dir_s, pwm_s, dir_d, pwm_d;
   logic                 pwm_edge, dir_chg;
   logic [NUM_GATES-1:0] req, gate_q;
   logic                 allow, trip, sc_latch, pbat_q;

   hbg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dir_in, pwm_in}),
      .q     (sync_q)
   );
   assign {dir_s, pwm_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_d  <= 1'b0;
         pwm_d  <= 1'b0;
         pbat_q <= 1'b0;
      end else begin
         dir_d  <= dir_s;
         pwm_d  <= pwm_s;
         pbat_q <= pbat_low;
      end
   end

   assign pwm_edge = pwm_s ^ pwm_d;
   assign dir_chg  = dir_s ^ dir_d;
   assign req      = bridge_request(dir_s, pwm_s);
   assign allow    = enable && !pbat_low && !sc_latch && !trip;

   for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
      hbg_leg #(.CNT_W(CNT_W)) u_leg (
         .clk     (clk),
         .rst_n   (rst_n),
         .req_hi  (req[2*l]),
         .req_lo  (req[2*l+1]),
         .allow   (allow),
         .restart (dir_chg),
         .dead    (dead_cycles),
         .hi_q    (gate_q[2*l]),
         .lo_q    (gate_q[2*l+1])
      );
   end

   hbg_desat #(.NG(NUM_GATES), .CNT_W(CNT_W)) u_desat (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_q   (gate_q),
      .desat    (desat_in),
      .blank    (blank_cycles),
      .pwm_edge (pwm_edge),
      .trip     (trip),
      .sc_latch (sc_latch)
   );

   assign gate_on    = gate_q;
   assign short_flag = sc_latch | pbat_q;

   p_enable_masks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (gate_on == '0));
   p_pbat_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pbat_low |=> (gate_on == '0 && short_flag));
   p_no_cross_leg_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_on[GI_HB] && gate_on[GI_LB]) && !(gate_on[GI_HA] && gate_on[GI_LA]));
endmodule

// File: tb/hbridge_gate_seq_bench.sv
module hbridge_gate_seq_bench;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b1, dir = 1'b0, pwm = 1'b1, pbat = 1'b0;
   logic [3:0]    desat = '0;
   logic [CW-1:0] dead = CW'(3), blank = CW'(2);
   logic [3:0]    g;
   logic          flag;
   int            n_chk = 0, n_bad = 0;
   logic          done = 1'b0;

   always #10 clk = ~clk;

   hbridge_gate_seq #(.CNT_W(CW), .SYNC_STAGES(2)) u_hbridge_gate_seq (
      .clk(clk), .rst_n(rst_n), .enable(en), .dir_in(dir), .pwm_in(pwm),
      .desat_in(desat), .pbat_low(pbat), .dead_cycles(dead), .blank_cycles(blank),
      .gate_on(g), .short_flag(flag)
   );

   // {en, dir, pwm, pbat, desat[3:0], gate[3:0], flag, req[3:0]}
   localparam int NV = 16;
   localparam logic [16:0] VEC [NV] = '{
      {1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b0,4'd1},  // R1 disabled
      {1'b1,1'b0,1'b0,1'b0,4'b0000,4'b0101,1'b0,4'd2},  // R2 pwm low
      {1'b1,1'b0,1'b1,1'b0,4'b0000,4'b1001,1'b0,4'd2},  // R2 pwm high
      {1'b1,1'b1,1'b1,1'b0,4'b0000,4'b0110,1'b0,4'd3},  // R3 pwm high
      {1'b1,1'b1,1'b0,1'b0,4'b0000,4'b0101,1'b0,4'd3},  // R3 pwm low
      {1'b0,1'b1,1'b1,1'b0,4'b0000,4'b0000,1'b0,4'd1},  // R1 disabled
      {1'b1,1'b1,1'b1,1'b0,4'b0000,4'b0110,1'b0,4'd3},  // R3
      {1'b1,1'b1,1'b1,1'b1,4'b0000,4'b0000,1'b1,4'd9},  // R9 droop
      {1'b1,1'b1,1'b1,1'b0,4'b0000,4'b0110,1'b0,4'd9},  // R9 recovered
      {1'b1,1'b0,1'b1,1'b0,4'b0000,4'b1001,1'b0,4'd2},  // R2
      {1'b1,1'b0,1'b1,1'b0,4'b1000,4'b0000,1'b1,4'd7},  // R7 desat on LB
      {1'b1,1'b0,1'b1,1'b0,4'b0000,4'b0000,1'b1,4'd8},  // R8 held
      {1'b1,1'b1,1'b1,1'b0,4'b0000,4'b0000,1'b1,4'd8},  // R8 dir change no release
      {1'b1,1'b0,1'b0,1'b0,4'b0000,4'b0101,1'b0,4'd8},  // R8 pwm edge releases
      {1'b1,1'b0,1'b0,1'b0,4'b0010,4'b0101,1'b0,4'd7},  // R7 desat on off gate
      {1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b0,4'd1}   // R1
   };

   task automatic check(input int req, input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: {gate,flag} got %b expected %b", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R10: reset state
      tick(3);
      check(10, {g, flag}, 5'b0000_0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         {en, dir, pwm, pbat, desat} = VEC[i][16:9];
         tick(12);
         check(int'(VEC[i][3:0]), {g, flag}, VEC[i][8:4]);
      end

      // R4: dead time of 4 cycles on leg B
      dead = CW'(4); en = 1'b1; dir = 1'b0; pwm = 1'b1; desat = '0;
      tick(15);
      check(2, {g, flag}, 5'b1001_0);
      pwm = 1'b0;
      begin
         int low_cnt = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (g[3:2] == 2'b00) low_cnt++;
         end
         check(4, {1'b0, 4'(low_cnt)}, 5'd4);
      end
      check(4, {g, flag}, 5'b0101_0);

      // R4: dead time 0 still leaves one cycle
      dead = '0; pwm = 1'b1;
      begin
         int low_cnt = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (g[3:2] == 2'b00) low_cnt++;
         end
         check(4, {1'b0, 4'(low_cnt)}, 5'd1);
      end
      check(4, {g, flag}, 5'b1001_0);

      // R5: reversal with pwm high, dead 3
      dead = CW'(3); dir = 1'b1;
      begin
         int off_cnt = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (g == 4'b0000) off_cnt++;
         end
         check(5, {1'b0, 4'(off_cnt)}, 5'd3);
      end
      check(5, {g, flag}, 5'b0110_0);

      // R7: blanking of 5 cycles, comparator already set when LA turns on
      dead = CW'(1); blank = CW'(5); pwm = 1'b0;
      tick(10);
      check(3, {g, flag}, 5'b0101_0);
      pwm = 1'b1; desat = 4'b0010;
      begin
         int on_cnt = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (g[1]) on_cnt++;
         end
         check(7, {1'b0, 4'(on_cnt)}, 5'd6);
      end
      check(7, {g, flag}, 5'b0000_1);

      // R8: direction change does not release, pwm edge does
      dir = 1'b0;
      tick(10);
      check(8, {g, flag}, 5'b0000_1);
      desat = '0; pwm = 1'b0;
      tick(10);
      check(8, {g, flag}, 5'b0101_0);

      // R6: 100% duty in both directions stays constant
      pwm = 1'b1;
      tick(10);
      begin
         int bad = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (g !== 4'b1001) bad++;
         end
         check(6, {1'b0, 4'(bad)}, 5'd0);
      end
      dir = 1'b1;
      tick(10);
      begin
         int bad = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (g !== 4'b0110) bad++;
         end
         check(6, {1'b0, 4'(bad)}, 5'd0);
      end

      // R9: exact one-edge response to droop and to its removal
      pbat = 1'b1;
      tick(1);
      check(9, {g, flag}, 5'b0000_1);
      pbat = 1'b0;
      tick(1);
      check(9, {g, flag}, 5'b0110_0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule